// File: doc/BRIEF.md
# ADC Conversion Result and Status Register Bank

This block is the register file that sits behind a multi-channel analog-to-digital converter. Each time the converter finishes a sample it raises a one-cycle result strobe with the channel number and the raw sample. The bank stores the sample in that channel's data register and in a shared most-recent-result register. It then updates a set of status flags. Depending on the resolution mode, the stored value is right-aligned as either an 8-bit or a 10-bit quantity.

Software reaches the bank through a simple single-cycle register bus. Reads are combinational, and some of them have side effects on the flags:
- Reading a channel's data register acknowledges that channel's completion flag.
- Reading the most-recent-result register acknowledges the data-ready flag.
- Reading the status word acknowledges every overrun flag, both per-channel and global.

An enable mask selects which status bits drive the single interrupt line. The mask is set and cleared through separate write addresses and has its own readback address. Conversion sequencing and bulk transfer engines live outside the bank.

Word addresses: 0 status (read), 1 mask set (write), 2 mask clear (write), 3 mask readback (read), 4 most-recent result (read), 8+c data of channel c (read).

Top module: `adc_result_bank`

## Requirements
- R1: After reset all data registers, all status bits and the interrupt mask read as zero, and `irq` is low.
- R2: A result strobe stores the sample in the data register of channel `res_ch` (address 8+ch) and in the most-recent register (address 4). The stored values are readable from the next cycle. With `res_mode`=1 all 10 bits are kept. With `res_mode`=0 only bits 7:0 are kept and bits 9:8 read as zero.
- R3: Status bit `ch` (0..7) is the completion flag of channel `ch`. A result on that channel sets it, and a read of address 8+ch clears it. When both occur in the same cycle, the set wins.
- R4: Status bit 8+ch is channel `ch`'s overrun flag. It sets when a result on `ch` arrives while completion bit `ch` is still set, unless the same cycle also reads address 8+ch.
- R5: Status bit 16 (data ready) sets on every result and clears on a read of address 4. When both occur in the same cycle, the set wins.
- R6: Status bit 17 (global overrun) sets when a result arrives while bit 16 is set, unless the same cycle also reads address 4.
- R7: A read of address 0 returns the status as held before that cycle and clears bits 8..15 and 17 at that edge. Bits 0..7 and 16 are left unchanged. A flag that is set in the same cycle stays set.
- R8: Writing address 1 sets every mask bit whose write-data bit is 1, and writing address 2 clears every mask bit whose write-data bit is 1. Address 3 reads back the 18-bit mask, with mask bit n enabling status bit n.
- R9: `irq` is high exactly when some status bit and its mask bit are both 1. It follows the registered flags and mask without further delay.
- R10: A read of any unmapped address (5, 6, 7, 16 and above) returns zero and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe: a conversion result is present |
| res_ch | input | 3 | Channel the result belongs to |
| res_data | input | 10 | Raw conversion sample |
| res_mode | input | 1 | 1 = 10-bit result, 0 = 8-bit result |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational. The bench therefore samples `bus_rdata` one nanosecond after it drives a read at the falling edge, which is before the edge that applies the read's side effects. Flag, mask and data changes caused by a result strobe or a register access land on the next rising edge. `irq` follows that edge with no extra register, so every check of state or `irq` is made at the falling edge that follows the stimulus's single rising edge. Same-cycle collision cases drive the result strobe and the clearing read in the same half-period, so both meet the same edge, as the set-wins rules require.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
   localparam int unsigned RB_ADDR_W = 5;
   localparam logic [RB_ADDR_W-1:0] ADR_STATUS  = 5'd0;
   localparam logic [RB_ADDR_W-1:0] ADR_MSK_SET = 5'd1;
   localparam logic [RB_ADDR_W-1:0] ADR_MSK_CLR = 5'd2;
   localparam logic [RB_ADDR_W-1:0] ADR_MSK_RD  = 5'd3;
   localparam logic [RB_ADDR_W-1:0] ADR_LAST    = 5'd4;
   localparam logic [RB_ADDR_W-1:0] ADR_CH_BASE = 5'd8;
   localparam int unsigned MAX_CH = 16;

   typedef struct packed {
      logic rd_status;
      logic rd_last;
      logic wr_set;
      logic wr_clr;
   } bus_dec_t;
endpackage

// File: rtl/adc_rb_chan.sv
module adc_rb_chan #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned CH_W   = 3,
   parameter int unsigned IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_ch,
   input  logic [DATA_W-1:0] res_val,
   input  logic              rd_hit,
   input  logic              rd_status,
   output logic [DATA_W-1:0] data_q,
   output logic              eoc_q,
   output logic              ovr_q
);
   logic hit;
   assign hit = res_valid && (res_ch == CH_W'(IDX));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         eoc_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (hit) data_q <= res_val;
         if (hit)         eoc_q <= 1'b1;
         else if (rd_hit) eoc_q <= 1'b0;
         if (hit && eoc_q && !rd_hit) ovr_q <= 1'b1;
         else if (rd_status)          ovr_q <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_rb_last.sv
module adc_rb_last #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_val,
   input  logic              rd_last,
   input  logic              rd_status,
   output logic [DATA_W-1:0] data_q,
   output logic              drdy_q,
   output logic              govre_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         drdy_q  <= 1'b0;
         govre_q <= 1'b0;
      end else begin
         if (res_valid) data_q <= res_val;
         if (res_valid)    drdy_q <= 1'b1;
         else if (rd_last) drdy_q <= 1'b0;
         if (res_valid && drdy_q && !rd_last) govre_q <= 1'b1;
         else if (rd_status)                  govre_q <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_rb_irq.sv
module adc_rb_irq #(
   parameter int unsigned STAT_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [STAT_W-1:0] wdata,
   input  logic [STAT_W-1:0] status,
   output logic [STAT_W-1:0] mask_q,
   output logic              irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= '0;
      else if (wr_set) mask_q <= mask_q | wdata;
      else if (wr_clr) mask_q <= mask_q & ~wdata;
   end

   assign irq = |(status & mask_q);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
   import adc_rb_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 10,
   parameter int unsigned LOW_W  = 8,
   parameter int unsigned BUS_W  = 32,
   localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 res_valid,
   input  logic [CH_W-1:0]      res_ch,
   input  logic [DATA_W-1:0]    res_data,
   input  logic                 res_mode,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [RB_ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 irq
);
   localparam int unsigned STAT_W = 2*NUM_CH + 2;
   localparam int unsigned DRDY_B = 2*NUM_CH;
   localparam int unsigned GOV_B  = 2*NUM_CH + 1;

   generate
      if (NUM_CH < 2 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("NUM_CH out of range");
      end
      if (STAT_W > BUS_W || DATA_W > BUS_W) begin : g_bad_bus
         $error("BUS_W too narrow for status or data");
      end
      if (LOW_W > DATA_W || LOW_W == 0) begin : g_bad_low
         $error("LOW_W must lie in 1..DATA_W");
      end
   endgenerate

   // result alignment
   logic [DATA_W-1:0] res_val;
   generate
      if (LOW_W < DATA_W) begin : g_dual_res
         always_comb begin
            res_val = res_data;
            if (!res_mode) res_val[DATA_W-1:LOW_W] = '0;
         end
      end else begin : g_single_res
         logic unused_mode;
         assign unused_mode = res_mode;
         assign res_val     = res_data;
      end
   endgenerate

   // bus decode
   logic     rd_en, wr_en;
   bus_dec_t dec;
   assign rd_en         = bus_sel && !bus_wr;
   assign wr_en         = bus_sel && bus_wr;
   assign dec.rd_status = rd_en && (bus_addr == ADR_STATUS);
   assign dec.rd_last   = rd_en && (bus_addr == ADR_LAST);
   assign dec.wr_set    = wr_en && (bus_addr == ADR_MSK_SET);
   assign dec.wr_clr    = wr_en && (bus_addr == ADR_MSK_CLR);

   logic [DATA_W-1:0] ch_data [NUM_CH];
   logic [NUM_CH-1:0] eoc_v, ovr_v, rd_ch;
   logic [DATA_W-1:0] last_data;
   logic              drdy_q, govre_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] mask_q;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign rd_ch[i] = rd_en && (bus_addr == ADR_CH_BASE + RB_ADDR_W'(i));
         adc_rb_chan #(.DATA_W(DATA_W), .CH_W(CH_W), .IDX(i)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .res_valid (res_valid),
            .res_ch    (res_ch),
            .res_val   (res_val),
            .rd_hit    (rd_ch[i]),
            .rd_status (dec.rd_status),
            .data_q    (ch_data[i]),
            .eoc_q     (eoc_v[i]),
            .ovr_q     (ovr_v[i])
         );
      end
   endgenerate

   adc_rb_last #(.DATA_W(DATA_W)) u_last (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_val   (res_val),
      .rd_last   (dec.rd_last),
      .rd_status (dec.rd_status),
      .data_q    (last_data),
      .drdy_q    (drdy_q),
      .govre_q   (govre_q)
   );

   assign stat_q = {govre_q, drdy_q, ovr_v, eoc_v};

   logic [BUS_W-1:0] unused_wdata;
   assign unused_wdata = bus_wdata;

   adc_rb_irq #(.STAT_W(STAT_W)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_set (dec.wr_set),
      .wr_clr (dec.wr_clr),
      .wdata  (bus_wdata[STAT_W-1:0]),
      .status (stat_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         if (bus_addr == ADR_STATUS)      bus_rdata = BUS_W'(stat_q);
         else if (bus_addr == ADR_MSK_RD) bus_rdata = BUS_W'(mask_q);
         else if (bus_addr == ADR_LAST)   bus_rdata = BUS_W'(last_data);
         for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch[i]) bus_rdata = BUS_W'(ch_data[i]);
         end
      end
   end

   localparam int unsigned GOV_CHK = GOV_B + 1 - DRDY_B;
   generate
      if (GOV_CHK != 2) begin : g_bad_map
         $error("status map inconsistent");
      end
   endgenerate
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk
   import adc_rb_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CH_W   = 3,
   parameter int unsigned STAT_W = 18
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 res_valid,
   input logic [CH_W-1:0]      res_ch,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic [RB_ADDR_W-1:0] bus_addr,
   input logic [STAT_W-1:0]    wdata,
   input logic [STAT_W-1:0]    stat,
   input logic [STAT_W-1:0]    mask,
   input logic                 irq
);
   localparam int unsigned DB = 2*NUM_CH;

   logic rd_en, rd_own_ch, rd_last, rd_stat, wr_clr;
   assign rd_en     = bus_sel && !bus_wr;
   assign rd_own_ch = rd_en && (bus_addr == ADR_CH_BASE + RB_ADDR_W'(res_ch));
   assign rd_last   = rd_en && (bus_addr == ADR_LAST);
   assign rd_stat   = rd_en && (bus_addr == ADR_STATUS);
   assign wr_clr    = bus_sel && bus_wr && (bus_addr == ADR_MSK_CLR);

   p_eoc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && int'(res_ch) < NUM_CH) |=> stat[$past(res_ch)]);

   p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && int'(res_ch) < NUM_CH && stat[res_ch] && !rd_own_ch)
      |=> stat[NUM_CH + $past(res_ch)]);

   p_drdy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> stat[DB]);

   p_govre_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && stat[DB] && !rd_last) |=> stat[DB+1]);

   p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !res_valid) |=> (stat[DB+1] == 1'b0 && stat[DB-1:NUM_CH] == '0));

   p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((mask & $past(wdata)) == '0));

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

   p_irq_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == '0) |-> !irq);
endmodule

bind adc_result_bank adc_result_bank_chk #(
   .NUM_CH (NUM_CH),
   .CH_W   (CH_W),
   .STAT_W (STAT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .res_valid (res_valid),
   .res_ch    (res_ch),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .wdata     (bus_wdata[STAT_W-1:0]),
   .stat      (stat_q),
   .mask      (mask_q),
   .irq       (irq)
);

// File: tb/adc_result_bank_test.sv
`timescale 1ns/1ps
module adc_result_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [2:0]  res_ch = '0;
   logic [9:0]  res_data = '0;
   logic        res_mode = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   adc_result_bank uut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
      .res_data(res_data), .res_mode(res_mode), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one result strobe, edge consumed
   task automatic put_res(input int ch, input logic [9:0] d, input logic m);
      @(negedge clk);
      res_valid = 1'b1; res_ch = 3'(ch); res_data = d; res_mode = m;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_wrt(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_rd(5'd0, d);  check("R1 status", d, 32'h0);
      bus_rd(5'd3, d);  check("R1 mask", d, 32'h0);
      bus_rd(5'd8, d);  check("R1 ch0 data", d, 32'h0);
      bus_rd(5'd4, d);  check("R1 last data", d, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_capture();
      logic [31:0] d;
      put_res(3, 10'h2A5, 1'b1);
      bus_rd(5'd0, d);  check("R3 R5 status after result", d, 32'h10008);
      bus_rd(5'd11, d); check("R2 ch3 data 10-bit", d, 32'h2A5);
      bus_rd(5'd0, d);  check("R3 eoc cleared by data read", d, 32'h10000);
      bus_rd(5'd4, d);  check("R2 last data", d, 32'h2A5);
      bus_rd(5'd0, d);  check("R5 drdy cleared by last read", d, 32'h0);
   endtask

   task automatic t_mode8();
      logic [31:0] d;
      put_res(5, 10'h3FF, 1'b0);
      bus_rd(5'd13, d); check("R2 ch5 8-bit alignment", d, 32'hFF);
      bus_rd(5'd4, d);  check("R2 last 8-bit alignment", d, 32'hFF);
   endtask

   task automatic t_overrun();
      logic [31:0] d;
      put_res(1, 10'h011, 1'b1);
      put_res(1, 10'h122, 1'b1);
      bus_rd(5'd0, d);  check("R4 R6 overrun flags", d, 32'h30202);
      bus_rd(5'd0, d);  check("R7 overruns cleared, eoc/drdy kept", d, 32'h10002);
      bus_rd(5'd9, d);  check("R2 ch1 holds newest", d, 32'h122);
      bus_rd(5'd4, d);  check("R2 last holds newest", d, 32'h122);
      bus_rd(5'd0, d);  check("R3 R5 all clear", d, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      put_res(2, 10'h0AA, 1'b1);
      @(negedge clk);
      res_valid = 1'b1; res_ch = 3'd2; res_data = 10'h155; res_mode = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'd10;
      #1 d = bus_rdata;
      @(negedge clk);
      res_valid = 1'b0; bus_sel = 1'b0;
      check("R3 same-cycle read returns old data", d, 32'h0AA);
      bus_rd(5'd0, d);  check("R3 R4 set wins, no channel overrun", d, 32'h30004);
      bus_rd(5'd0, d);  check("R7 govre cleared", d, 32'h10004);
      // last read colliding with new result
      @(negedge clk);
      res_valid = 1'b1; res_ch = 3'd6; res_data = 10'h0F0; res_mode = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'd4;
      #1 d = bus_rdata;
      @(negedge clk);
      res_valid = 1'b0; bus_sel = 1'b0;
      check("R5 same-cycle last read returns old", d, 32'h155);
      bus_rd(5'd0, d);  check("R5 R6 drdy kept, no global overrun", d, 32'h10044);
      // overrun set while status read
      @(negedge clk);
      res_valid = 1'b1; res_ch = 3'd6; res_data = 10'h0F1; res_mode = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'd0;
      #1 d = bus_rdata;
      @(negedge clk);
      res_valid = 1'b0; bus_sel = 1'b0;
      check("R7 status read sees pre-edge value", d, 32'h10044);
      bus_rd(5'd0, d);  check("R7 flag set in same cycle survives", d, 32'h34044);
      bus_rd(5'd10, d); bus_rd(5'd14, d); bus_rd(5'd4, d);
      bus_rd(5'd0, d);  check("R3 R5 cleanup", d, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      put_res(0, 10'h001, 1'b1);
      check("R9 masked flag keeps irq low", {31'b0, irq}, 32'h0);
      bus_wrt(5'd1, 32'h1);
      check("R9 irq on enabled eoc0", {31'b0, irq}, 32'h1);
      bus_rd(5'd3, d);  check("R8 mask readback", d, 32'h1);
      bus_wrt(5'd2, 32'h1);
      check("R9 irq off after disable", {31'b0, irq}, 32'h0);
      bus_wrt(5'd1, 32'h10000);
      check("R9 irq on enabled drdy", {31'b0, irq}, 32'h1);
      bus_wrt(5'd1, 32'h20000);
      bus_rd(5'd3, d);  check("R8 mask set accumulates", d, 32'h30000);
      bus_rd(5'd4, d);
      check("R9 irq drops when drdy read", {31'b0, irq}, 32'h0);
      bus_wrt(5'd2, 32'h3FFFF);
      bus_rd(5'd3, d);  check("R8 mask cleared", d, 32'h0);
      bus_rd(5'd8, d);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      put_res(4, 10'h3C3, 1'b1);
      bus_rd(5'd7, d);  check("R10 addr 7 reads zero", d, 32'h0);
      bus_rd(5'd20, d); check("R10 addr 20 reads zero", d, 32'h0);
      bus_rd(5'd1, d);  check("R10 write-only addr reads zero", d, 32'h0);
      bus_rd(5'd0, d);  check("R10 flags untouched", d, 32'h10010);
      bus_rd(5'd12, d); bus_rd(5'd4, d);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_capture();
      t_mode8();
      t_overrun();
      t_collide();
      t_irq();
      t_unmapped();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule